// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block holds several independent down-counters. Each counter has a control register, a running count that software can only read, and a fixed count that software writes. On each selected tick the running count drops by one. When the count is already zero on a tick, the channel expires. A reload-mode channel then copies its fixed count back into the counter and keeps running. A one-shot channel stops at zero and waits until it is armed again. Each expiry sets a sticky per-channel flag, and that flag drives a level interrupt when it is enabled.

A channel takes its ticks from one of two sources: every clock, or the rising edges of a slow reference input that the block synchronizes itself. Any other source code stops the channel. A global register can freeze every counter at once or hold every channel in its reset state.

Each control register, and the global register, has three alias addresses. The aliases set, clear or toggle only the bits written as one, so software never needs a read-modify-write. With the update bit set, a write to the fixed count also loads the running counter at once. That gives an exact one-shot delay.

Top module: `dn_timer`

## Requirements
- R1: The register map is: global register at 0x00; channel n control at 0x20+0x40·n, running count at 0x30+0x40·n, fixed count at 0x40+0x40·n. After reset every register reads zero and every irq_o bit is low.
- R2: The control bit positions are: source code [3:0], reload bit 6, update bit 7, interrupt enable bit 14, status flag bit 15. All other bits read as zero. A write of all ones to the plain address reads back 0x000040CF.
- R3: Address bits [3:2] choose the write action on control and global registers: 0 replaces the value, 1 ORs in the written ones, 2 clears the written ones, 3 toggles them. The fixed count accepts only plain-address writes. The running count ignores all writes.
- R4: With source code 0xF the counter drops by one on every clock. After N is loaded, it reaches 0 after N clocks and expires on the next clock.
- R5: With source code 0xB the counter drops by one for each rising edge of slow_tick_i, after a two-stage synchronizer. Any code other than 0xF or 0xB stops the counter.
- R6: In one-shot mode (reload bit clear) the counter stays at 0 after expiry. No further expiry occurs until the fixed count is written again.
- R7: In reload mode, expiry copies the fixed count into the counter, so a fixed count N gives a period of N+1 ticks.
- R8: With the update bit set, a fixed-count write loads the running counter on that same clock. With the update bit clear, the running counter keeps counting undisturbed.
- R9: The status flag is set on expiry and is cleared only by writing a one to bit 15 through the clear alias. Plain, set and toggle writes leave the flag unchanged.
- R10: irq_o[n] is high exactly when channel n's flag and interrupt enable are both set.
- R11: Global bit 30 freezes every channel's counter while it is set.
- R12: While global bit 31 is set, every channel's registers are held at zero and channel writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow reference, asynchronous |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| irq_o | output | NCH | Per-channel interrupt |

## Verification
On every cycle, assertions check the following:
- the counter drops by exactly one on a tick, and holds when there is no tick and no load;
- a stopped one-shot counter sits at zero;
- the flag stays set until it is cleared;
- reload copies the fixed value;
- the slow tick pulse lasts one cycle;
- a write to the running-count address raises no write strobe.

Only the bench scenarios can show the rest:
- the address map and the arithmetic of the three aliases;
- the exact N+1 expiry timing and the reload period;
- how update-mode writes differ from plain fixed writes;
- counting on slow edges and stopping on unused codes;
- the effect of the freeze and soft-reset bits.

// File: rtl/dn_timer_pkg.sv
package dn_timer_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    AL_WR  = 2'd0,
    AL_SET = 2'd1,
    AL_CLR = 2'd2,
    AL_TOG = 2'd3
  } alias_e;

  localparam logic [3:0] SRC_FAST = 4'hF;
  localparam logic [3:0] SRC_SLOW = 4'hB;

  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IE     = 14;
  localparam int B_FLAG   = 15;
  localparam int G_FREEZE = 30;
  localparam int G_SRST   = 31;

  function automatic logic [REG_W-1:0] apply_alias(alias_e a, logic [REG_W-1:0] cur,
                                                   logic [REG_W-1:0] wd);
    case (a)
      AL_SET:  return cur | wd;
      AL_CLR:  return cur & ~wd;
      AL_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/dn_timer_slowsync.sv
module dn_timer_slowsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], slow_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~last_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dn_timer_regbus.sv
module dn_timer_regbus import dn_timer_pkg::*; #(
  parameter int NCH    = 3,
  parameter int ADDR_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [REG_W-1:0]           glob_i,
  input  logic [NCH-1:0][REG_W-1:0]  ctrl_i,
  input  logic [NCH-1:0][REG_W-1:0]  cnt_i,
  input  logic [NCH-1:0][REG_W-1:0]  fixed_i,
  output logic [REG_W-1:0]           rdata_o,
  output logic                       glob_we_o,
  output logic [NCH-1:0]             ctrl_we_o,
  output logic [NCH-1:0]             fixed_we_o,
  output alias_e                     alias_o
);
  localparam int IW = ADDR_W - 6;
  localparam logic [1:0] GRP_FIX = 2'd0;
  localparam logic [1:0] GRP_CTL = 2'd2;
  localparam logic [1:0] GRP_RUN = 2'd3;

  logic [1:0]    grp;
  logic [IW-1:0] idx;
  logic          glob_hit;
  logic [NCH-1:0] ctl_hit, run_hit, fix_hit;
  logic          unused_addr;

  assign alias_o     = alias_e'(addr_i[3:2]);
  assign grp         = addr_i[5:4];
  assign idx         = addr_i[ADDR_W-1:6];
  assign glob_hit    = req_i && grp == GRP_FIX && idx == '0;
  assign unused_addr = ^addr_i[1:0];

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign ctl_hit[n]    = req_i && grp == GRP_CTL && idx == IW'(n);
    assign run_hit[n]    = req_i && grp == GRP_RUN && idx == IW'(n);
    assign fix_hit[n]    = req_i && grp == GRP_FIX && idx == IW'(n + 1);
    assign ctrl_we_o[n]  = ctl_hit[n] && we_i;
    assign fixed_we_o[n] = fix_hit[n] && we_i && alias_o == AL_WR;
  end

  assign glob_we_o = glob_hit && we_i;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (glob_hit) rdata_o = glob_i;
      for (int n = 0; n < NCH; n++) begin
        if (ctl_hit[n]) rdata_o = ctrl_i[n];
        if (run_hit[n]) rdata_o = cnt_i[n];
        if (fix_hit[n]) rdata_o = fixed_i[n];
      end
    end
  end

  a_r3_run_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i[5:4] == 2'd3 |-> !glob_we_o && ctrl_we_o == '0 && fixed_we_o == '0);
  a_r3_fixed_alias_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i[3:2] != 2'd0 |-> fixed_we_o == '0);
endmodule

// File: rtl/dn_timer_chan.sv
module dn_timer_chan import dn_timer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             freeze_i,
  input  logic             slow_pulse_i,
  input  logic             ctrl_we_i,
  input  logic             fixed_we_i,
  input  alias_e           alias_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] fixed_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0]       src_q;
  logic             reload_q, update_q, ie_q, flag_q, done_q;
  logic [CNT_W-1:0] cnt_q, fixed_q;
  logic [REG_W-1:0] ctrl_nxt;
  logic             src_tick, tick, load_now, expire, flag_clr;
  logic             unused_bits;

  assign ctrl_o = {16'b0, flag_q, ie_q, 6'b0, update_q, reload_q, 2'b0, src_q};
  assign ctrl_nxt = apply_alias(alias_i, ctrl_o, wdata_i);
  assign unused_bits = ^{ctrl_nxt, wdata_i};

  always_comb begin
    case (src_q)
      SRC_FAST: src_tick = 1'b1;
      SRC_SLOW: src_tick = slow_pulse_i;
      default:  src_tick = 1'b0;
    endcase
  end

  assign tick     = src_tick && !freeze_i;
  assign load_now = fixed_we_i && update_q;
  assign expire   = tick && cnt_q == '0 && !done_q && !load_now;
  assign flag_clr = ctrl_we_i && alias_i == AL_CLR && wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      reload_q <= 1'b0;
      update_q <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      done_q   <= 1'b1;
      cnt_q    <= '0;
      fixed_q  <= '0;
    end else if (srst_i) begin
      src_q    <= '0;
      reload_q <= 1'b0;
      update_q <= 1'b0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      done_q   <= 1'b1;
      cnt_q    <= '0;
      fixed_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        src_q    <= ctrl_nxt[3:0];
        reload_q <= ctrl_nxt[B_RELOAD];
        update_q <= ctrl_nxt[B_UPDATE];
        ie_q     <= ctrl_nxt[B_IE];
      end
      if (flag_clr)    flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;

      if (load_now) begin
        cnt_q <= wdata_i[CNT_W-1:0];
      end else if (expire) begin
        if (reload_q) cnt_q <= fixed_q;
        else          done_q <= 1'b1;
      end else if (tick && cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end

      // any fixed write re-arms the channel
      if (fixed_we_i) begin
        fixed_q <= wdata_i[CNT_W-1:0];
        done_q  <= 1'b0;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign fixed_o = fixed_q;
  assign irq_o   = flag_q & ie_q;

  a_r4_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q != '0 && !fixed_we_i && !srst_i |=> cnt_q == $past(cnt_q) - ONE);
  a_r5_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !fixed_we_i && !srst_i |=> $stable(cnt_q));
  a_r6_done_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q == '0);
  a_r7_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && reload_q && !srst_i |=> cnt_q == $past(fixed_q));
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !flag_clr && !srst_i |=> flag_q);
endmodule

// File: rtl/dn_timer.sv
module dn_timer import dn_timer_pkg::*; #(
  parameter int NCH    = 3,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int IW = ADDR_W - 6;

  initial begin
    if (NCH + 1 > (1 << IW)) $error("address space too small for NCH channels");
    if (CNT_W > REG_W) $error("CNT_W exceeds register width");
  end

  logic                      freeze_q, srst_q, slow_pulse, glob_we;
  logic [REG_W-1:0]          glob_cur, glob_nxt;
  logic [NCH-1:0]            ctrl_we, fixed_we;
  logic [NCH-1:0][REG_W-1:0] ctrl_rd, cnt_rd, fixed_rd;
  alias_e                    wr_alias;
  logic                      unused_glob;

  assign glob_cur    = {srst_q, freeze_q, 30'b0};
  assign glob_nxt    = apply_alias(wr_alias, glob_cur, wdata_i);
  assign unused_glob = ^glob_nxt[29:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      srst_q   <= 1'b0;
    end else if (glob_we) begin
      freeze_q <= glob_nxt[G_FREEZE];
      srst_q   <= glob_nxt[G_SRST];
    end
  end

  dn_timer_slowsync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slow_i (slow_tick_i),
    .pulse_o(slow_pulse)
  );

  dn_timer_regbus #(.NCH(NCH), .ADDR_W(ADDR_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .glob_i    (glob_cur),
    .ctrl_i    (ctrl_rd),
    .cnt_i     (cnt_rd),
    .fixed_i   (fixed_rd),
    .rdata_o   (rdata_o),
    .glob_we_o (glob_we),
    .ctrl_we_o (ctrl_we),
    .fixed_we_o(fixed_we),
    .alias_o   (wr_alias)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [CNT_W-1:0] cnt_w, fixed_w;

    dn_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .srst_i      (srst_q),
      .freeze_i    (freeze_q),
      .slow_pulse_i(slow_pulse),
      .ctrl_we_i   (ctrl_we[n]),
      .fixed_we_i  (fixed_we[n]),
      .alias_i     (wr_alias),
      .wdata_i     (wdata_i),
      .ctrl_o      (ctrl_rd[n]),
      .cnt_o       (cnt_w),
      .fixed_o     (fixed_w),
      .irq_o       (irq_o[n])
    );

    assign cnt_rd[n]   = REG_W'(cnt_w);
    assign fixed_rd[n] = REG_W'(fixed_w);
  end

  a_r12_srst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q && $past(srst_q) |-> irq_o == '0);
endmodule

// File: tb/dn_timer_bench.sv
module dn_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dn_timer u_dn_timer (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; exactly one rising edge passes
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    req = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_slow(int n);
    for (int i = 0; i < n; i++) begin
      slow = 1'b1; edges(3);
      slow = 1'b0; edges(3);
    end
  endtask

  task automatic t_reset;
    chk_rd("R1 global reset", 8'h00, 32'h0);
    for (int c = 0; c < 3; c++) begin
      chk_rd("R1 ctrl reset", 8'(8'h20 + c * 8'h40), 32'h0);
      chk_rd("R1 run reset", 8'(8'h30 + c * 8'h40), 32'h0);
      chk_rd("R1 fixed reset", 8'(8'h40 + c * 8'h40), 32'h0);
    end
    chk("R1 irq reset", 32'(irq), 32'h0);
  endtask

  task automatic t_fields;
    wr(8'h20, 32'hFFFF_FFFF);
    chk_rd("R2 field mask", 8'h20, 32'h0000_40CF);
    wr(8'h20, 32'h0);
    chk_rd("R2 clear", 8'h20, 32'h0);
  endtask

  task automatic t_alias;
    wr(8'h20, 32'h3);
    wr(8'h24, 32'h4000);
    chk_rd("R3 set alias", 8'h20, 32'h4003);
    wr(8'h28, 32'h1);
    chk_rd("R3 clr alias", 8'h20, 32'h4002);
    wr(8'h2C, 32'h42);
    chk_rd("R3 tog alias", 8'h20, 32'h4040);
    wr(8'h44, 32'h1234);
    chk_rd("R3 fixed alias ignored", 8'h40, 32'h0);
    wr(8'h30, 32'h55);
    chk_rd("R3 run read-only", 8'h30, 32'h0);
    wr(8'h04, 32'h4000_0000);
    chk_rd("R3 global set", 8'h00, 32'h4000_0000);
    wr(8'h08, 32'h4000_0000);
    chk_rd("R3 global clr", 8'h00, 32'h0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(8'h20, 32'h408F);
    wr(8'h40, 32'd5);
    chk_rd("R8 update load", 8'h30, 32'd5);
    edges(5);
    chk_rd("R4 zero after N", 8'h30, 32'd0);
    chk("R4 no early irq", 32'(irq[0]), 32'h0);
    edges(1);
    chk("R10 irq on expiry", 32'(irq[0]), 32'h1);
    chk_rd("R4 flag on N+1", 8'h20, 32'hC08F);
    wr(8'h28, 32'h8000);
    edges(3);
    rd(8'h20, d);
    chk("R6 no re-expiry", d, 32'h408F);
    chk_rd("R6 holds zero", 8'h30, 32'd0);
  endtask

  task automatic t_reload;
    wr(8'h60, 32'h4F);
    wr(8'h80, 32'd3);
    chk_rd("R7 before reload", 8'h70, 32'd0);
    edges(1);
    chk_rd("R7 first reload", 8'h70, 32'd3);
    chk_rd("R7 flag", 8'h60, 32'h804F);
    chk("R10 gated by ie", 32'(irq[1]), 32'h0);
    wr(8'h68, 32'h8000);
    chk_rd("R7 counting", 8'h70, 32'd2);
    edges(2);
    chk_rd("R7 at zero", 8'h70, 32'd0);
    edges(1);
    chk_rd("R7 period N+1", 8'h70, 32'd3);
    chk_rd("R7 flag again", 8'h60, 32'h804F);
    wr(8'h60, 32'h0);
    wr(8'h68, 32'h8000);
  endtask

  task automatic t_noupdate;
    wr(8'h40, 32'd20);
    wr(8'h28, 32'h80);
    wr(8'h40, 32'd7);
    chk_rd("R8 no load w/o update", 8'h30, 32'd18);
    chk_rd("R8 fixed stored", 8'h40, 32'd7);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h8000);
  endtask

  task automatic t_flag;
    wr(8'h20, 32'h408F);
    wr(8'h40, 32'd1);
    edges(2);
    chk("R10 irq set", 32'(irq[0]), 32'h1);
    chk_rd("R9 flag set", 8'h20, 32'hC08F);
    wr(8'h24, 32'h8000);
    chk_rd("R9 set alias no effect", 8'h20, 32'hC08F);
    wr(8'h2C, 32'h8000);
    chk_rd("R9 tog alias no effect", 8'h20, 32'hC08F);
    wr(8'h20, 32'h408F);
    chk_rd("R9 plain write no effect", 8'h20, 32'hC08F);
    wr(8'h28, 32'h4000);
    chk("R10 ie off", 32'(irq[0]), 32'h0);
    chk_rd("R10 flag kept", 8'h20, 32'h808F);
    wr(8'h24, 32'h4000);
    chk("R10 ie on", 32'(irq[0]), 32'h1);
    wr(8'h28, 32'h8000);
    chk_rd("R9 clr alias", 8'h20, 32'h408F);
    chk("R9 irq gone", 32'(irq[0]), 32'h0);
  endtask

  task automatic t_slow;
    wr(8'hA0, 32'h8B);
    wr(8'hC0, 32'd100);
    pulse_slow(4);
    edges(4);
    chk_rd("R5 slow edges", 8'hB0, 32'd96);
    wr(8'hA0, 32'h83);
    pulse_slow(2);
    edges(4);
    chk_rd("R5 unused code stops", 8'hB0, 32'd96);
  endtask

  task automatic t_freeze;
    wr(8'h20, 32'h8F);
    wr(8'h40, 32'd50);
    wr(8'h04, 32'h4000_0000);
    chk_rd("R11 freeze entry", 8'h30, 32'd49);
    edges(5);
    chk_rd("R11 frozen", 8'h30, 32'd49);
    wr(8'h08, 32'h4000_0000);
    chk_rd("R11 exit", 8'h30, 32'd49);
    edges(2);
    chk_rd("R11 resumed", 8'h30, 32'd47);
  endtask

  task automatic t_srst;
    wr(8'h04, 32'h8000_0000);
    chk_rd("R12 global bit", 8'h00, 32'h8000_0000);
    wr(8'h20, 32'hF);
    chk_rd("R12 ctrl held", 8'h20, 32'h0);
    chk_rd("R12 count held", 8'h30, 32'h0);
    chk_rd("R12 fixed held", 8'h40, 32'h0);
    chk_rd("R12 slow ch held", 8'hB0, 32'h0);
    wr(8'h08, 32'h8000_0000);
    chk_rd("R12 released", 8'h00, 32'h0);
    chk_rd("R12 ctrl after", 8'h20, 32'h0);
    chk("R12 irq", 32'(irq), 32'h0);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_fields();
    t_alias();
    t_oneshot();
    t_reload();
    t_noupdate();
    t_flag();
    t_slow();
    t_freeze();
    t_srst();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule